// File: doc/BRIEF.md
# Recursive Carry-Select Wide Adder

This block adds two wide unsigned operands and a carry-in in a single combinational pass. It does not use one long ripple chain. It builds the sum as a tree. At the bottom are 32-bit adders. Every level above joins two halves by computing the low half once and the high half twice, once assuming a carry of zero and once assuming a carry of one. The low half's carry then picks the correct high result through a 2:1 mux.

Because the two high-half candidates are ready at the same time as the low half, each level adds only one mux delay to the path. At the default width of 256 bits the deepest path is one 32-bit leaf addition followed by three muxes. The block is meant for wide modular arithmetic datapaths, where it sits between operand registers and the reduction logic. The width is a parameter and must be 32 times a power of two.

Top module: `wide_csel_adder`

## Requirements
- R1: `{carry_o, sum_o}` equals the full-precision sum `op_a + op_b + carry_in` for any operand values.
- R2: `carry_in` enters only the lowest 32-bit leaf; with both operands zero and `carry_in` = 1 the sum is 1 and `carry_o` is 0.
- R3: all-ones plus zero with `carry_in` = 1, or all-ones plus one with `carry_in` = 0, yields `sum_o` = 0 and `carry_o` = 1.
- R4: a carry generated below any 32-bit boundary k (bits k*32-1..0 of `op_a` all ones, `op_b` = 1) propagates so that `sum_o` has only bit k*32 set, for every boundary in the word.
- R5: adding zero is the identity: with one operand zero and `carry_in` = 0, `sum_o` equals the other operand and `carry_o` is 0 (all-zero inputs give all-zero outputs).
- R6: `carry_o` is the carry of the selected top-level high half; two operands with only the top bit set give `sum_o` = 0 and `carry_o` = 1.
- R7: the block is purely combinational; outputs settle within the same clock period as a change of inputs, with no register stage.
- R8: any width of 32 times a power of two, including 64, gives the same full-precision behaviour as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the sum |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The bench checks the points where a carry-select tree typically goes wrong. The first is a carry that must ripple across each 32-bit seam. A mux driven by the wrong carry, or with swapped inputs, would leave that seam's upper bits unchanged or set wrongly. The all-ones-plus-one case and the top-bit overflow case target the final carry-out. Returning the zero-carry candidate's carry there would drop the overflow. Isolated carry-in cases catch a carry-in wired into a high-half child instead of only the lowest leaf. Random operands at both 256 and 64 bits catch mis-sliced halves.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int unsigned LEAF_W = 32;

    function automatic bit width_ok(input int unsigned w);
        int unsigned q;
        if (w < LEAF_W || (w % LEAF_W) != 0) return 1'b0;
        q = w / LEAF_W;
        return (q & (q - 1)) == 0;
    endfunction
endpackage

// File: rtl/csa_leaf.sv
module csa_leaf #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    logic [W:0] total;

    always_comb begin
        total = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
        s_o   = total[W-1:0];
        c_o   = total[W];
    end
endmodule

// File: rtl/csa_mux.sv
module csa_mux #(
    parameter int unsigned W = 33
) (
    input  logic         sel_i,
    input  logic [W-1:0] zero_i,
    input  logic [W-1:0] one_i,
    output logic [W-1:0] out_o
);
    always_comb out_o = sel_i ? one_i : zero_i;
endmodule

// File: rtl/csa_node.sv
module csa_node
    import csa_pkg::*;
#(
    parameter int unsigned W = 256
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    localparam int unsigned H = W / 2;

    generate
        if (W <= LEAF_W) begin : g_leaf
            csa_leaf #(.W(W)) u_leaf (
                .a_i(a_i), .b_i(b_i), .c_i(c_i), .s_o(s_o), .c_o(c_o)
            );
        end else begin : g_split
            logic [H-1:0] lo_s, hi0_s, hi1_s;
            logic         lo_c, hi0_c, hi1_c;
            logic [H:0]   hi_pick;

            csa_node #(.W(H)) u_lo (
                .a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .c_i(c_i),
                .s_o(lo_s), .c_o(lo_c)
            );
            csa_node #(.W(H)) u_hi0 (
                .a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .c_i(1'b0),
                .s_o(hi0_s), .c_o(hi0_c)
            );
            csa_node #(.W(H)) u_hi1 (
                .a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .c_i(1'b1),
                .s_o(hi1_s), .c_o(hi1_c)
            );
            csa_mux #(.W(H+1)) u_sel (
                .sel_i(lo_c), .zero_i({hi0_c, hi0_s}), .one_i({hi1_c, hi1_s}),
                .out_o(hi_pick)
            );

            assign s_o = {hi_pick[H-1:0], lo_s};
            assign c_o = hi_pick[H];
        end
    endgenerate
endmodule

// File: rtl/wide_csel_adder.sv
module wide_csel_adder #(
    parameter int unsigned WIDTH = 256
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    csa_node #(.W(WIDTH)) u_root (
        .a_i(op_a), .b_i(op_b), .c_i(carry_in), .s_o(sum_o), .c_o(carry_o)
    );
endmodule

// File: rtl/wide_csel_adder_chk.sv
module wide_csel_adder_chk
    import csa_pkg::*;
#(
    parameter int unsigned WIDTH = 256
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o
);
    logic [WIDTH:0] ref_total;
    logic [LEAF_W:0] ref_leaf;
    logic           known;

    initial begin
        AST_WIDTH_LEGAL: assert (width_ok(WIDTH)); // R8
    end

    always_comb begin
        known     = !$isunknown({op_a, op_b, carry_in});
        ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        ref_leaf  = {1'b0, op_a[LEAF_W-1:0]} + {1'b0, op_b[LEAF_W-1:0]} + {{LEAF_W{1'b0}}, carry_in};
        if (known) begin
            AST_FULL_SUM: assert ({carry_o, sum_o} == ref_total); // R1
            AST_LOW_LEAF: assert (sum_o[LEAF_W-1:0] == ref_leaf[LEAF_W-1:0]); // R2
            if (op_a == '0 && !carry_in) begin
                AST_ZERO_IDENTITY: assert (sum_o == op_b && !carry_o); // R5
            end
            if (op_a[WIDTH-1] && op_b[WIDTH-1]) begin
                AST_TOP_OVERFLOW: assert (carry_o); // R6
            end
            if (op_a == '1 && op_b == '0 && carry_in) begin
                AST_ALL_ONES_WRAP: assert (sum_o == '0 && carry_o); // R3
            end
        end
    end
endmodule

bind wide_csel_adder wide_csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sum_o(sum_o), .carry_o(carry_o)
);

// File: tb/wide_csel_adder_bench.sv
module wide_csel_adder_bench;
    localparam int unsigned W  = 256;
    localparam int unsigned WS = 64;

    typedef struct {
        logic [W:0]  exp_w;
        logic [WS:0] exp_s;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] a, b;
    logic         ci;
    logic [W-1:0] s;
    logic         co;
    logic [WS-1:0] s_small;
    logic          co_small;

    item_t sb[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit drive_done = 1'b0;

    wide_csel_adder #(.WIDTH(W)) u_wide_csel_adder (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_o(s), .carry_o(co)
    );
    wide_csel_adder #(.WIDTH(WS)) u_small (
        .op_a(a[WS-1:0]), .op_b(b[WS-1:0]), .carry_in(ci), .sum_o(s_small), .carry_o(co_small)
    );

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string tag);
        item_t it;
        @(posedge clk);
        a = x; b = y; ci = c;
        it.exp_w = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        it.exp_s = {1'b0, x[WS-1:0]} + {1'b0, y[WS-1:0]} + {{WS{1'b0}}, c};
        it.tag   = tag;
        sb.push_back(it);
    endtask

    // Monitor: outputs are combinational (R7), sampled half a period after drive
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if ({co, s} !== it.exp_w) begin
                    n_fail++;
                    $display("FAIL %s (R7) width %0d: got %h expected %h", it.tag, W, {co, s}, it.exp_w);
                end
                n_checks++;
                if ({co_small, s_small} !== it.exp_s) begin
                    n_fail++;
                    $display("FAIL R8 %s width %0d: got %h expected %h", it.tag, WS, {co_small, s_small}, it.exp_s);
                end
            end
        end
    end

    initial begin
        a = '0; b = '0; ci = 1'b0;
        apply('0, '0, 1'b0, "R5 zero inputs");
        apply('0, '0, 1'b1, "R2 carry-in only");
        apply('1, '0, 1'b1, "R3 all-ones plus carry-in");
        apply('1, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R3 all-ones plus one");
        apply({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, "R6 top-bit overflow");
        for (int k = 1; k < W / 32; k++) begin
            logic [W-1:0] pat;
            pat = '0;
            for (int j = 0; j < k * 32; j++) pat[j] = 1'b1;
            apply(pat, {{(W-1){1'b0}}, 1'b1}, 1'b0, $sformatf("R4 boundary %0d", k));
            apply(pat, '0, 1'b1, $sformatf("R4 boundary %0d via carry-in", k));
        end
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] x, y;
            for (int w = 0; w < W / 32; w++) begin
                x[w*32 +: 32] = $urandom;
                y[w*32 +: 32] = $urandom;
            end
            apply(x, y, 1'($urandom), "R1 random");
        end
        begin
            logic [W-1:0] x;
            for (int w = 0; w < W / 32; w++) x[w*32 +: 32] = $urandom;
            apply(x, '0, 1'b0, "R5 add zero");
            apply('0, x, 1'b0, "R5 zero plus operand");
        end
        @(posedge clk);
        drive_done = 1'b1;
    end

    initial begin
        int cycles = 0;
        while (!(drive_done && sb.size() == 0) && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (cycles >= 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
        end
        @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule